// File: doc/BRIEF.md
# Ternary Table Update Engine

This block holds the storage of a small ternary match table and the engine that software uses to change it. Each key row carries key words, mask words (held in don't-care-high form, so a mask bit of 1 lets the key bit take any value) and an 8-bit type-group field made of four 2-bit sub-word codes. A type-group code of 0 marks a sub-entry as unused. Every row of the wider result side carries action words and 32-bit counter words. The result side may be deeper than the key side.

Software loads a staging cache through a plain word-addressed register port. It then writes the control word with the start bit set. The engine moves data between the cache and the table one row per clock. It can write one row, read one row, shift a block of rows up or down, or copy the cache into a run of rows. Each of the three sections (key, action, counter) can be excluded from a command. The start bit stays high while the command runs and clears by itself, so software can poll it.

Top module: `tcam_cmd_engine`

## Requirements
- R1: The register port decodes word addresses as follows: 0 control, 1 row count (8 bits), 2 cache type-group (8 bits), 8..11 cache key words, 12..15 cache mask words, 16..19 cache action words and 20..23 cache counter words. Only the first KW, AW or CW words of each group exist. Any other address reads 0, and a write to it has no effect.
- R2: Command 0 (write) copies the enabled cache sections into the row given by control bits 15:8.
- R3: Command 1 (read) copies the enabled sections of the addressed row into the cache.
- R4: Control bit 4 disables the key section (key, mask and type-group), bit 5 the action section and bit 6 the counter section. A disabled section is neither read nor written.
- R5: Control bit 0 is the start bit. Control bits 3:1 hold the command. The start bit reads 1 from the clock edge that accepts the command, stays 1 for exactly one clock per row processed, and then clears without any further write.
- R6: Command 2 (shift up) copies each row in [addr, addr+count-1] to the row one below it, in ascending order. A copy whose source or destination is outside a section's depth is skipped for that section.
- R7: Command 3 (shift down) copies each row in [addr, addr+count-1] to the row one above it, in descending order. The result is that the block moves up by one row intact.
- R8: Command 4 (initialize) writes the cache into the rows [addr, addr+count-1] and into no other row.
- R9: A command with the key section enabled and an address at or beyond ROWS changes no storage. Its start bit clears one cycle after it is accepted.
- R10: With the key section disabled, the action and counter rows from ROWS up to XROWS-1 can be written and read.
- R11: While the start bit is 1, writes to every register are ignored.
- R12: A shift or initialize with a row count of 0, or a command code above 4, touches no row and finishes after one cycle.
- R13: After reset, every table row has a type-group of 0 and zero counters, and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Copy of the start bit |

## Verification
The hardest case to reach is a shift over overlapping rows. In this case, the wrong processing order silently copies one row into several. The stimulus first writes four rows with distinct patterns. It then shifts three of them up and two of them back down, and reads each affected row back through the cache, so that any overwrite before copy shows up as a duplicated pattern. Writes are also issued while a multi-row command is still running. Afterwards the count and type-group cache registers are read back to show that those writes were dropped.

// File: rtl/tcam_cmd_engine.sv
module tcam_cmd_engine #(
  parameter int ROWS  = 8,
  parameter int XROWS = 10,
  parameter int KW    = 2,
  parameter int AW    = 2,
  parameter int CW    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy
);
  localparam int KB = (ROWS  > 1) ? $clog2(ROWS)  : 1;
  localparam int XB = (XROWS > 1) ? $clog2(XROWS) : 1;
  localparam logic [2:0] C_WR = 3'd0, C_RD = 3'd1, C_UP = 3'd2, C_DN = 3'd3, C_INIT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;
  state_t state;

  logic [31:0] t_key [ROWS][KW];
  logic [31:0] t_msk [ROWS][KW];
  logic [7:0]  t_tg  [ROWS];
  logic [31:0] t_act [XROWS][AW];
  logic [31:0] t_cnt [XROWS][CW];

  logic [31:0] c_key [4];
  logic [31:0] c_msk [4];
  logic [31:0] c_act [4];
  logic [31:0] c_cnt [4];
  logic [7:0]  c_tg;

  logic [2:0] cmd_q, dis_q;
  logic [7:0] row_q, mcnt_q;
  logic       shot_q;
  logic [8:0] cur, left;

  wire        accept = reg_we && !shot_q;
  wire [1:0]  wi     = reg_addr[1:0];
  wire [2:0]  w_cmd  = reg_wdata[3:1];
  wire [2:0]  w_dis  = reg_wdata[6:4];
  wire [7:0]  w_row  = reg_wdata[15:8];
  wire [8:0]  w_n    = (w_cmd == C_WR || w_cmd == C_RD) ? 9'd1 : {1'b0, mcnt_q};
  wire        w_bad  = (!w_dis[0] && {1'b0, w_row} >= 9'(ROWS)) || w_n == 9'd0 || w_cmd > C_INIT;

  wire [8:0]  dst  = (cmd_q == C_UP) ? cur - 9'd1 : (cmd_q == C_DN) ? cur + 9'd1 : cur;
  wire        en_e = !dis_q[0] && cur < 9'(ROWS);
  wire        en_a = !dis_q[1] && cur < 9'(XROWS);
  wire        en_c = !dis_q[2] && cur < 9'(XROWS);
  wire        dk   = dst < 9'(ROWS);
  wire        dx   = dst < 9'(XROWS);
  wire [KB-1:0] ks = cur[KB-1:0];
  wire [KB-1:0] kd = dst[KB-1:0];
  wire [XB-1:0] xs = cur[XB-1:0];
  wire [XB-1:0] xd = dst[XB-1:0];

  assign busy = shot_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[4:2])
      3'd0: case (reg_addr[1:0])
              2'd0: reg_rdata = {16'b0, row_q, 1'b0, dis_q, cmd_q, shot_q};
              2'd1: reg_rdata = {24'b0, mcnt_q};
              2'd2: reg_rdata = {24'b0, c_tg};
              default: reg_rdata = '0;
            endcase
      3'd2: if (int'(wi) < KW) reg_rdata = c_key[wi];
      3'd3: if (int'(wi) < KW) reg_rdata = c_msk[wi];
      3'd4: if (int'(wi) < AW) reg_rdata = c_act[wi];
      3'd5: if (int'(wi) < CW) reg_rdata = c_cnt[wi];
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; shot_q <= 1'b0; cmd_q <= '0; dis_q <= '0; row_q <= '0;
      mcnt_q <= '0; cur <= '0; left <= '0; c_tg <= '0;
      for (int i = 0; i < 4; i++) begin
        c_key[i] <= '0; c_msk[i] <= '0; c_act[i] <= '0; c_cnt[i] <= '0;
      end
      for (int r = 0; r < ROWS; r++) begin
        t_tg[r] <= '0;
        for (int i = 0; i < KW; i++) begin t_key[r][i] <= '0; t_msk[r][i] <= '0; end
      end
      for (int r = 0; r < XROWS; r++) begin
        for (int i = 0; i < AW; i++) t_act[r][i] <= '0;
        for (int i = 0; i < CW; i++) t_cnt[r][i] <= '0;
      end
    end else begin
      if (accept) begin
        case (reg_addr[4:2])
          3'd0: case (reg_addr[1:0])
                  2'd0: begin
                    cmd_q <= w_cmd; dis_q <= w_dis; row_q <= w_row;
                    if (reg_wdata[0]) begin
                      shot_q <= 1'b1;
                      left   <= w_n;
                      cur    <= (w_cmd == C_DN) ? {1'b0, w_row} + w_n - 9'd1 : {1'b0, w_row};
                      state  <= w_bad ? S_DONE : S_RUN;
                    end
                  end
                  2'd1: mcnt_q <= reg_wdata[7:0];
                  2'd2: c_tg   <= reg_wdata[7:0];
                  default: ;
                endcase
          3'd2: if (int'(wi) < KW) c_key[wi] <= reg_wdata;
          3'd3: if (int'(wi) < KW) c_msk[wi] <= reg_wdata;
          3'd4: if (int'(wi) < AW) c_act[wi] <= reg_wdata;
          3'd5: if (int'(wi) < CW) c_cnt[wi] <= reg_wdata;
          default: ;
        endcase
      end

      case (state)
        S_RUN: begin
          case (cmd_q)
            C_WR, C_INIT: begin
              if (en_e) begin
                t_tg[ks] <= c_tg;
                for (int i = 0; i < KW; i++) begin t_key[ks][i] <= c_key[i]; t_msk[ks][i] <= c_msk[i]; end
              end
              if (en_a) for (int i = 0; i < AW; i++) t_act[xs][i] <= c_act[i];
              if (en_c) for (int i = 0; i < CW; i++) t_cnt[xs][i] <= c_cnt[i];
            end
            C_RD: begin
              if (en_e) begin
                c_tg <= t_tg[ks];
                for (int i = 0; i < KW; i++) begin c_key[i] <= t_key[ks][i]; c_msk[i] <= t_msk[ks][i]; end
              end
              if (en_a) for (int i = 0; i < AW; i++) c_act[i] <= t_act[xs][i];
              if (en_c) for (int i = 0; i < CW; i++) c_cnt[i] <= t_cnt[xs][i];
            end
            default: begin
              if (en_e && dk) begin
                t_tg[kd] <= t_tg[ks];
                for (int i = 0; i < KW; i++) begin t_key[kd][i] <= t_key[ks][i]; t_msk[kd][i] <= t_msk[ks][i]; end
              end
              if (en_a && dx) for (int i = 0; i < AW; i++) t_act[xd][i] <= t_act[xs][i];
              if (en_c && dx) for (int i = 0; i < CW; i++) t_cnt[xd][i] <= t_cnt[xs][i];
            end
          endcase
          left <= left - 9'd1;
          cur  <= (cmd_q == C_DN) ? cur - 9'd1 : cur + 9'd1;
          if (left == 9'd1) begin
            state  <= S_IDLE;
            shot_q <= 1'b0;
          end
        end
        S_DONE: begin
          state  <= S_IDLE;
          shot_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  AST_BUSY_DROPS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_q && reg_we) |=> ($stable(mcnt_q) && $stable(c_tg))) else $error("busy write taken"); // R11
  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !shot_q) else $error("idle with start bit"); // R5
  AST_RUN_HAS_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> (left != 9'd0 && shot_q)) else $error("run without rows"); // R5
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE) |=> (state == S_IDLE && !shot_q)) else $error("abort lingers"); // R9
  AST_SHOT_FALL_FROM_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shot_q) |-> ($past(state) != S_IDLE)) else $error("start bit fell in idle"); // R5
endmodule

// File: tb/sim_tcam_cmd_engine.sv
module sim_tcam_cmd_engine;
  localparam int KW = 2, AW = 2, CW = 2;
  localparam logic [2:0] C_WR = 3'd0, C_RD = 3'd1, C_UP = 3'd2, C_DN = 3'd3, C_INIT = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, busy;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  tcam_cmd_engine #(.ROWS(8), .XROWS(10), .KW(KW), .AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy));

  // {address, write data, expected readback}
  localparam logic [68:0] VEC [8] = '{
    {5'd8,  32'h1234_5678, 32'h1234_5678},
    {5'd9,  32'hCAFE_0001, 32'hCAFE_0001},
    {5'd10, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'd12, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    {5'd17, 32'hA5A5_0000, 32'hA5A5_0000},
    {5'd21, 32'h0000_0077, 32'h0000_0077},
    {5'd2,  32'h0000_01C3, 32'h0000_00C3},
    {5'd3,  32'hDEAD_BEEF, 32'h0000_0000}
  };

  function automatic logic [31:0] kv(int s, int i); return s * 32'h0101_0101 + i; endfunction
  function automatic logic [31:0] av(int s, int i); return s * 32'h0010_0001 + 32'h100 + i; endfunction
  function automatic logic [31:0] cv(int s, int i); return s * 7 + i + 1; endfunction
  function automatic logic [31:0] tv(int s); return {24'b0, 8'(s) ^ 8'hA5}; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_cmd(logic [2:0] c, logic [7:0] row, logic [2:0] dis, output int cyc);
    wr(5'd0, {16'b0, row, 1'b0, dis, c, 1'b1});
    cyc = 0;
    while (busy && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  task automatic fill(int s);
    wr(5'd2, tv(s));
    for (int i = 0; i < KW; i++) begin wr(5'(8 + i), kv(s, i)); wr(5'(12 + i), ~kv(s, i)); end
    for (int i = 0; i < AW; i++) wr(5'(16 + i), av(s, i));
    for (int i = 0; i < CW; i++) wr(5'(20 + i), cv(s, i));
  endtask

  task automatic chk_cache(string req, int ks, int as_, int cs);
    logic [31:0] d;
    rd(5'd2, d); chk(req, d, tv(ks));
    for (int i = 0; i < KW; i++) begin
      rd(5'(8 + i), d);  chk(req, d, kv(ks, i));
      rd(5'(12 + i), d); chk(req, d, ~kv(ks, i));
    end
    for (int i = 0; i < AW; i++) begin rd(5'(16 + i), d); chk(req, d, av(as_, i)); end
    for (int i = 0; i < CW; i++) begin rd(5'(20 + i), d); chk(req, d, cv(cs, i)); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(5'd0, d); chk("R13 ctrl", d, 32'h0);
    chk("R13 busy", {31'b0, busy}, 32'h0);

    // R1 cache register map via the vector table
    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][68:64], VEC[v][63:32]);
      rd(VEC[v][68:64], d);
      chk("R1 map", d, VEC[v][31:0]);
    end

    // R13 row 5 is cleared after reset; R3 read
    fill(1);
    do_cmd(C_RD, 8'd5, 3'b000, cyc);
    rd(5'd2, d);  chk("R13 tg", d, 32'h0);
    rd(5'd20, d); chk("R13 cnt", d, 32'h0);
    rd(5'd8, d);  chk("R13 key", d, 32'h0);

    // R2 write then R3 read back, R5 single row takes one cycle
    fill(2);
    do_cmd(C_WR, 8'd2, 3'b000, cyc);
    chk("R5 one row", cyc, 1);
    fill(3);
    do_cmd(C_RD, 8'd2, 3'b000, cyc);
    chk_cache("R2 R3 roundtrip", 2, 2, 2);

    // R4 disables on write and on read
    fill(4);
    do_cmd(C_WR, 8'd2, 3'b001, cyc);
    fill(5);
    do_cmd(C_RD, 8'd2, 3'b010, cyc);
    chk_cache("R4 disable", 2, 5, 4);

    // R6 shift up over overlapping rows
    for (int r = 0; r < 4; r++) begin fill(11 + r); do_cmd(C_WR, 8'(r), 3'b000, cyc); end
    wr(5'd1, 32'd3);
    do_cmd(C_UP, 8'd1, 3'b000, cyc);
    chk("R5 three rows", cyc, 3);
    do_cmd(C_RD, 8'd0, 3'b000, cyc); chk_cache("R6 row0", 12, 12, 12);
    do_cmd(C_RD, 8'd2, 3'b000, cyc); chk_cache("R6 row2", 14, 14, 14);
    do_cmd(C_RD, 8'd3, 3'b000, cyc); chk_cache("R6 row3", 14, 14, 14);

    // R7 shift down
    wr(5'd1, 32'd2);
    do_cmd(C_DN, 8'd0, 3'b000, cyc);
    do_cmd(C_RD, 8'd1, 3'b000, cyc); chk_cache("R7 row1", 12, 12, 12);
    do_cmd(C_RD, 8'd2, 3'b000, cyc); chk_cache("R7 row2", 13, 13, 13);
    do_cmd(C_RD, 8'd3, 3'b000, cyc); chk_cache("R7 row3 kept", 14, 14, 14);

    // R8 initialize rows 4..6, row 7 untouched
    fill(20);
    wr(5'd1, 32'd3);
    do_cmd(C_INIT, 8'd4, 3'b000, cyc);
    fill(21);
    do_cmd(C_RD, 8'd6, 3'b000, cyc); chk_cache("R8 row6", 20, 20, 20);
    do_cmd(C_RD, 8'd4, 3'b000, cyc); chk_cache("R8 row4", 20, 20, 20);
    do_cmd(C_RD, 8'd7, 3'b000, cyc);
    rd(5'd2, d);  chk("R8 row7 tg", d, 32'h0);
    rd(5'd16, d); chk("R8 row7 act", d, 32'h0);

    // R9 key-enabled access beyond key depth is dropped
    fill(40);
    do_cmd(C_WR, 8'd8, 3'b000, cyc);
    chk("R9 abort cycles", cyc, 1);
    fill(41);
    do_cmd(C_RD, 8'd8, 3'b001, cyc);
    rd(5'd16, d); chk("R9 act row8", d, 32'h0);
    rd(5'd20, d); chk("R9 cnt row8", d, 32'h0);

    // R10 deep result rows reachable with key section off
    fill(42);
    do_cmd(C_WR, 8'd8, 3'b001, cyc);
    fill(43);
    do_cmd(C_RD, 8'd8, 3'b001, cyc);
    chk_cache("R10 row8", 43, 42, 42);

    // R11 writes while busy are dropped; R5 four-row timing
    wr(5'd1, 32'd4);
    do_cmd(C_UP, 8'd5, 3'b111, cyc);
    chk("R5 four rows", cyc, 4);
    wr(5'd0, {16'b0, 8'd5, 1'b0, 3'b111, C_UP, 1'b1});
    wr(5'd1, 32'd9);
    wr(5'd2, 32'h55);
    while (busy) @(negedge clk);
    rd(5'd1, d); chk("R11 count kept", d, 32'd4);
    rd(5'd2, d); chk("R11 tg kept", d, tv(43));

    // R12 zero count and bad command code
    wr(5'd1, 32'd0);
    fill(30);
    do_cmd(C_INIT, 8'd0, 3'b000, cyc);
    chk("R12 zero count cycles", cyc, 1);
    do_cmd(3'd5, 8'd0, 3'b000, cyc);
    chk("R12 bad code cycles", cyc, 1);
    do_cmd(C_RD, 8'd0, 3'b000, cyc);
    chk_cache("R12 row0 kept", 12, 12, 12);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule